// File: doc/BRIEF.md
# Five-Channel Prescaled Down-Counting Timer

This block is a memory-mapped timer with five independent down-counting channels. Software reaches it over a plain 32-bit register bus that carries a byte address, a write strobe, write data and registered read data. The input clock first passes through one of two shared 8-bit prescalers. Channels 0 and 1 share the first prescaler, and channels 2 to 4 share the second. Each channel then applies its own power-of-two divider. The result is one count tick per channel.

Software programs a channel in three steps. It writes the count and compare buffers. It pulses the channel's manual-update bit, which copies the buffers into the live counter. It then sets start, in either one-shot or auto-reload mode. When a counter reaches zero, the channel raises a sticky status flag. Each flag is gated by an enable bit and drives one interrupt line per channel. Channels 0 to 3 also drive a level flag. That flag reports whether the live count is at or below the compare value, and it can be inverted.

Top module: `ptimer5`

## Requirements
- R1: After reset, every register reads 0, no interrupt line is high, and all counters are stopped.
- R2: A running channel receives one tick every (P+1)·2^S clock cycles. P is the prescaler field of its group: bits 7:0 of address 0x00 for channels 0 and 1, bits 15:8 for channels 2 to 4. S is the channel's select nibble at bits 4c+3:4c of address 0x04. Select values 0 to 4 divide by 1, 2, 4, 8 and 16. Reading 0x00 returns only bits 15:0, and reading 0x04 returns only bits 19:0.
- R3: The control register at 0x08 holds a group of bits for each channel. Channel 0's group starts at bit 0, and channel c≥1's group starts at bit 4(c+1). Within a group, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. Channel 4 has only three bits, with auto-reload at bit 22. Undefined bits read 0, so writing all ones reads back 0x007FFF0F.
- R4: While a channel's manual-update bit is set, its counter is loaded from the count buffer and its compare value from the compare buffer. Its count observation register then returns the count buffer value.
- R5: With start set and manual update clear, the counter decrements by exactly one on each tick. With start clear, it holds its value.
- R6: In auto-reload mode, a tick that finds the counter at zero reloads it from the count buffer. A count buffer of N therefore gives one zero event every N+1 ticks.
- R7: In one-shot mode, the counter stays at zero after reaching it, and no further events occur.
- R8: A count of 0 loaded for a one-shot run never sets the channel's status bit.
- R9: At 0x44, bits 4:0 are the interrupt enables and bits 9:5 are the status flags. Writing 1 to a status bit clears it. Interrupt line c goes high one cycle after status c and enable c are both set.
- R10: A status bit is set on the tick at which the counter steps from 1 to 0. If that set and a software clear land in the same cycle, the bit ends up set.
- R11: For channels 0 to 3, cmp_flag[c] is 1 while the count is at or below the compare value, XORed with the invert bit.
- R12: The address map is as follows. The count buffer is at 0x0C+12c and the compare buffer at 0x10+12c, for c from 0 to 3. Channel 4's count buffer is at 0x3C. The observation registers are at 0x14+12c for c from 0 to 3, and at 0x40 for channel 4. Channel 4 has no compare buffer, and writes to 0x40 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the address |
| irq | output | 5 | Per-channel interrupt, status AND enable |
| cmp_flag | output | 4 | Compare level flags of channels 0 to 3 |

## Verification
The bench sweeps all five channels over several prescaler values, divider selects and reload counts. It measures the interval between zero events and compares it with the computed tick period. A swapped prescaler group, or a channel that reads the wrong divider nibble, would miss that interval by a factor. It checks the control-bit layout that is easy to get wrong: the gap after channel 0 and the displaced auto-reload bit of channel 4. A design that used a regular layout would fail the readback check or never reload. The bench also places a status clear in the exact cycle of a zero event, so a design that let the clear win would lose an interrupt. A one-shot run with a count of zero must stay silent, which exposes any design that treats "counter equals zero" as the event.

// File: rtl/ptimer5_pkg.sv
package ptimer5_pkg;

  localparam int NCH  = 5;
  localparam int NGRP = 2;

  localparam int A_PSC = 'h00;
  localparam int A_SEL = 'h04;
  localparam int A_CTL = 'h08;
  localparam int A_INT = 'h44;

  // first control bit of a channel; one group is skipped after channel 0
  function automatic int ctl_base(input int c);
    return (c == 0) ? 0 : 4 * (c + 1);
  endfunction

  function automatic int grp_of(input int c);
    return (c < 2) ? 0 : 1;
  endfunction

  function automatic int cntb_addr(input int c);
    return 'h0C + 12 * c;
  endfunction

  function automatic int cmpb_addr(input int c);
    return 'h10 + 12 * c;
  endfunction

  function automatic int obs_addr(input int c);
    return (c == NCH - 1) ? 'h40 : 'h14 + 12 * c;
  endfunction

  function automatic logic [31:0] ctl_mask();
    logic [31:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      if (c == NCH - 1) m[ctl_base(c) +: 3] = 3'b111;
      else              m[ctl_base(c) +: 4] = 4'b1111;
    end
    return m;
  endfunction

endpackage

// File: rtl/ptimer5_prescale.sv
module ptimer5_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc_i,
  output logic             pulse_o
);

  logic [PSC_W-1:0] cnt_q;

  assign pulse_o = (cnt_q >= psc_i);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (pulse_o) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2
  psc_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && psc_i != '0) |=> (!pulse_o || psc_i != $past(psc_i)));

endmodule

// File: rtl/ptimer5_divider.sv
module ptimer5_divider #(
  parameter int SEL_W = 4,
  parameter int MAXSH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [MAXSH-1:0] dcnt_q;
  logic [MAXSH-1:0] mask;

  always_comb begin
    if (sel_i >= SEL_W'(MAXSH)) mask = '1;
    else                        mask = MAXSH'((1 << sel_i) - 1);
  end

  assign tick_o = pulse_i && ((dcnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)          dcnt_q <= '0;
    else if (pulse_i) dcnt_q <= dcnt_q + 1'b1;
  end

endmodule

// File: rtl/ptimer5_chan.sv
module ptimer5_chan #(
  parameter int CNT_W   = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             manual_i,
  input  logic             auto_i,
  input  logic             inv_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cntb_i,
  input  logic [CNT_W-1:0] cmpb_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run   = start_i && !manual_i;
  assign cnt_o = cnt_q;
  assign hit_o = run && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (manual_i)          cnt_q <= cntb_i;
    else if (run && tick_i) begin
      if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
      else if (auto_i)          cnt_q <= cntb_i;
    end
  end

  generate
    if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmp_q;
      logic             flag_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_q  <= '0;
          flag_q <= 1'b0;
        end else begin
          if (manual_i) cmp_q <= cmpb_i;
          flag_q <= (cnt_q <= cmp_q) ^ inv_i;
        end
      end
      assign flag_o = flag_q;
    end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = ^{cmpb_i, inv_i};
      assign flag_o = 1'b0;
    end
  endgenerate

  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    manual_i |=> (cnt_q == $past(cntb_i)));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !manual_i) |=> $stable(cnt_q));
  // R5
  dec_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick_i && cnt_q == '0 && auto_i) |=> (cnt_q == $past(cntb_i)));
  // R7
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick_i && cnt_q == '0 && !auto_i) |=> (cnt_q == '0));

endmodule

// File: rtl/ptimer5.sv
module ptimer5
  import ptimer5_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int AW    = 8,
  parameter int PSC_W = 8,
  parameter int SEL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NCH-1:0]  irq,
  output logic [NCH-2:0]  cmp_flag
);

  localparam logic [31:0] CTL_MASK = ctl_mask();

  logic [NGRP-1:0][PSC_W-1:0] psc_q;
  logic [NCH-1:0][SEL_W-1:0]  sel_q;
  logic [31:0]                ctrl_q;
  logic [CNT_W-1:0]           cntb_q [NCH];
  logic [CNT_W-1:0]           cmpb_q [NCH];
  logic [CNT_W-1:0]           cnt_w  [NCH];
  logic [NCH-1:0]             en_q, sts_q, hit_w, clr;
  logic [NGRP-1:0]            pulse_w;
  logic [31:0]                rd;

  for (genvar g = 0; g < NGRP; g++) begin : g_psc
    ptimer5_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst(rst), .psc_i(psc_q[g]), .pulse_o(pulse_w[g]));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int B    = ctl_base(c);
    localparam int G    = grp_of(c);
    localparam bit LAST = (c == NCH - 1);
    logic tick, flag;

    ptimer5_divider #(.SEL_W(SEL_W), .MAXSH(4)) u_div (
      .clk(clk), .rst(rst), .pulse_i(pulse_w[G]), .sel_i(sel_q[c]), .tick_o(tick));

    ptimer5_chan #(.CNT_W(CNT_W), .HAS_CMP(!LAST)) u_ch (
      .clk(clk), .rst(rst),
      .start_i(ctrl_q[B]), .manual_i(ctrl_q[B+1]),
      .auto_i(LAST ? ctrl_q[B+2] : ctrl_q[B+3]),
      .inv_i(LAST ? 1'b0 : ctrl_q[B+2]),
      .tick_i(tick), .cntb_i(cntb_q[c]), .cmpb_i(cmpb_q[c]),
      .cnt_o(cnt_w[c]), .hit_o(hit_w[c]), .flag_o(flag));

    if (!LAST) begin : g_flag
      assign cmp_flag[c] = flag;
    end else begin : g_noflag
      logic unused_flag;
      assign unused_flag = flag;
    end
  end

  assign clr = (bus_we && bus_addr == AW'(A_INT)) ? bus_wdata[2*NCH-1:NCH] : '0;

  always_comb begin
    rd = '0;
    if (bus_addr == AW'(A_PSC))
      for (int g = 0; g < NGRP; g++) rd[g*8 +: PSC_W] = psc_q[g];
    if (bus_addr == AW'(A_SEL))
      for (int c = 0; c < NCH; c++) rd[c*4 +: SEL_W] = sel_q[c];
    if (bus_addr == AW'(A_CTL)) rd = ctrl_q;
    if (bus_addr == AW'(A_INT)) begin
      rd[NCH-1:0]     = en_q;
      rd[2*NCH-1:NCH] = sts_q;
    end
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == AW'(cntb_addr(c))) rd = 32'(cntb_q[c]);
      if (c < NCH - 1 && bus_addr == AW'(cmpb_addr(c))) rd = 32'(cmpb_q[c]);
      if (bus_addr == AW'(obs_addr(c))) rd = 32'(cnt_w[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q     <= '0;
      sel_q     <= '0;
      ctrl_q    <= '0;
      en_q      <= '0;
      sts_q     <= '0;
      irq       <= '0;
      bus_rdata <= '0;
      for (int c = 0; c < NCH; c++) begin
        cntb_q[c] <= '0;
        cmpb_q[c] <= '0;
      end
    end else begin
      if (bus_we) begin
        if (bus_addr == AW'(A_PSC))
          for (int g = 0; g < NGRP; g++) psc_q[g] <= bus_wdata[g*8 +: PSC_W];
        if (bus_addr == AW'(A_SEL))
          for (int c = 0; c < NCH; c++) sel_q[c] <= bus_wdata[c*4 +: SEL_W];
        if (bus_addr == AW'(A_CTL)) ctrl_q <= bus_wdata & CTL_MASK;
        if (bus_addr == AW'(A_INT)) en_q <= bus_wdata[NCH-1:0];
        for (int c = 0; c < NCH; c++) begin
          if (bus_addr == AW'(cntb_addr(c))) cntb_q[c] <= bus_wdata[CNT_W-1:0];
          if (c < NCH - 1 && bus_addr == AW'(cmpb_addr(c)))
            cmpb_q[c] <= bus_wdata[CNT_W-1:0];
        end
      end
      sts_q     <= (sts_q & ~clr) | hit_w;
      irq       <= sts_q & en_q;
      bus_rdata <= rd;
    end
  end

  // R10
  sts_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit_w) |=> ((sts_q & $past(hit_w)) == $past(hit_w)));

endmodule

// File: tb/ptimer5_tb_top.sv
module ptimer5_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  irq;
  logic [3:0]  cmp_flag;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  ptimer5 dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cmp_flag(cmp_flag));

  function automatic int a_cnt(input int c); return 12 + 12 * c; endfunction
  function automatic int a_cmp(input int c); return 16 + 12 * c; endfunction
  function automatic int a_obs(input int c); return (c == 4) ? 64 : 20 + 12 * c; endfunction
  function automatic int gbase(input int c); return (c == 0) ? 0 : 4 * c + 4; endfunction
  function automatic int abit(input int c); return (c == 4) ? 22 : gbase(c) + 3; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 8'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 8'(a); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int c, input logic v);
    while (irq[c] !== v) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int cyc;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd('h00, v); chk("R1 psc", v, 0);
    rd('h08, v); chk("R1 ctrl", v, 0);
    rd('h44, v); chk("R1 int", v, 0);
    rd(a_obs(2), v); chk("R1 obs", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R3 control layout, R2 field widths
    wr('h08, 32'hFFFF_FFFF); rd('h08, v); chk("R3 ctrl mask", v, 32'h007F_FF0F);
    wr('h08, 0); rd('h08, v); chk("R3 ctrl clear", v, 0);
    wr('h00, 32'hFFFF_FFFF); rd('h00, v); chk("R2 psc width", v, 32'h0000_FFFF);
    wr('h04, 32'hFFFF_FFFF); rd('h04, v); chk("R2 sel width", v, 32'h000F_FFFF);
    wr('h00, 0); wr('h04, 0);

    // R4 manual load, R12 map
    wr(a_cnt(2), 1234); wr('h08, 1 << 13); idle(2);
    rd(a_obs(2), v); chk("R4 ch2 obs", v, 1234);
    wr(a_cnt(4), 777); wr('h08, 1 << 21); idle(2);
    rd('h40, v); chk("R4 ch4 obs", v, 777);
    wr('h08, 0); wr(a_cnt(4), 5);
    rd('h3C, v); chk("R12 ch4 cntb", v, 5);
    rd('h40, v); chk("R12 ch4 obs kept", v, 777);
    wr('h40, 55); idle(2);
    rd('h40, v); chk("R12 write 0x40 ignored", v, 777);
    wr(a_cmp(0), 32'hABCD); rd(a_cmp(0), v); chk("R12 ch0 cmpb", v, 32'hABCD);

    // R5 decrement and hold
    wr(a_cnt(1), 100); wr('h08, 1 << 9); idle(2); wr('h08, 1 << 8);
    idle(3);
    bus_addr = 8'(a_obs(1)); @(negedge clk); v = bus_rdata;
    idle(10); v2 = bus_rdata;
    chk("R5 decrement per tick", v - v2, 10);
    wr('h08, 0); idle(3);
    rd(a_obs(1), v); idle(10); rd(a_obs(1), v2);
    chk("R5 hold when stopped", v2, v);

    // R7 one-shot, R9 interrupt register
    wr('h44, 32'h3E0);
    wr(a_cnt(0), 5); wr('h08, 1 << 1); idle(2); wr('h08, 1 << 0);
    idle(30);
    rd(a_obs(0), v); chk("R7 stopped at zero", v, 0);
    rd('h44, v); chk("R10 status set", v, 32'h20);
    wr('h44, 1); idle(2); chk("R9 irq on", 32'(irq[0]), 1);
    wr('h44, 0); idle(2); chk("R9 irq masked", 32'(irq[0]), 0);
    rd('h44, v); chk("R9 status stays", v, 32'h20);
    wr('h44, 32'h21); idle(2); chk("R9 w1c irq off", 32'(irq[0]), 0);
    rd('h44, v); chk("R9 w1c status", v, 32'h1);
    idle(30);
    rd('h44, v); chk("R7 no second event", v, 32'h1);
    wr('h08, 0);

    // R8 zero count one-shot
    wr('h44, 32'h3E0);
    wr(a_cnt(3), 0); wr('h08, 1 << 17); idle(2); wr('h08, 1 << 16);
    idle(40);
    rd('h44, v); chk("R8 no event from zero", v & 32'h100, 0);
    wr('h08, 0);

    // R11 compare flag
    wr(a_cnt(1), 50); wr(a_cmp(1), 20); wr('h08, 1 << 9); idle(3);
    chk("R11 above", 32'(cmp_flag[1]), 0);
    wr('h08, (1 << 9) | (1 << 10)); idle(3);
    chk("R11 above inverted", 32'(cmp_flag[1]), 1);
    wr(a_cnt(1), 20); wr('h08, 1 << 9); idle(3);
    chk("R11 equal", 32'(cmp_flag[1]), 1);
    wr(a_cnt(1), 21); idle(3);
    chk("R11 one above", 32'(cmp_flag[1]), 0);
    wr(a_cnt(1), 19); idle(3);
    chk("R11 below", 32'(cmp_flag[1]), 1);
    wr('h08, (1 << 9) | (1 << 10)); idle(3);
    chk("R11 below inverted", 32'(cmp_flag[1]), 0);
    wr('h08, 0);

    // R10 set beats clear in the same cycle (ch0, period 4 cycles)
    wr('h00, 0); wr('h04, 0); wr('h44, 32'h3E0);
    wr(a_cnt(0), 3); wr('h08, (1 << 1) | (1 << 3)); idle(2);
    wr('h08, (1 << 0) | (1 << 3)); wr('h44, 1);
    wait_irq(0, 1'b1); wr('h44, 32'h21);
    wait_irq(0, 1'b0); wait_irq(0, 1'b1);
    wr('h44, 32'h21); idle(1); wr('h44, 32'h21);
    rd('h44, v); chk("R10 set wins over clear", v & 32'h20, 32'h20);
    wr('h08, 0); wr('h44, 32'h3E0);
    rd('h44, v); chk("R9 cleared after stop", v, 0);

    // R2 R6 period sweep
    for (int ch = 0; ch < 5; ch++) begin
      for (int s = 0; s < 3; s++) begin
        for (int p = 0; p < 2; p++) begin
          for (int k = 0; k < 2; k++) begin
            int n, gp, exp_per;
            n = 3 + 2 * k;
            gp = (ch < 2) ? 0 : 8;
            exp_per = (n + 1) * (p + 1) * (1 << s);
            wr('h00, (32'(p) << gp) | (32'd7 << (8 - gp)));
            wr('h04, (32'h0003_3333 & ~(32'hF << (4 * ch))) | (32'(s) << (4 * ch)));
            wr(a_cnt(ch), n);
            wr('h44, (32'd1 << ch) | 32'h3E0);
            wr('h08, (32'd1 << (gbase(ch) + 1)) | (32'd1 << abit(ch)));
            idle(2);
            wr('h08, (32'd1 << gbase(ch)) | (32'd1 << abit(ch)));
            wait_irq(ch, 1'b1);
            wr('h44, (32'd1 << ch) | (32'd1 << (ch + 5)));
            cyc = 1;
            while (irq[ch] === 1'b1) begin @(negedge clk); cyc++; end
            while (irq[ch] !== 1'b1) begin @(negedge clk); cyc++; end
            chk($sformatf("R2 R6 period ch%0d sel%0d psc%0d n%0d", ch, s, p, n),
                32'(cyc), 32'(exp_per));
            wr('h08, 0);
            wr('h44, 32'h3E0);
          end
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule